// File: doc/BRIEF.md
# Local Bus Transfer Controller

This controller sits on the card side of a PCI-to-local-bus bridge. When the bridge signals that it has an access pending, the controller raises a hold request for the local bus. It waits for the arbiter's acknowledge and then takes the address presented with the active-low address strobe. A read access streams words out of the acquisition FIFO, or returns a control register, one word per ready beat. A write access stores a single word into a control register. Either access ends on the beat that carries the active-low last-transfer strobe. The controller then passes through a completion state that drops the hold request, and returns to idle.

The current state is brought out on a three-bit port with a fixed encoding: 0 idle, 1 holding the bus, 2 read streaming, 3 single write, 4 completion. The FIFO occupies the address window selected by `FIFO_BASE`/`FIFO_MASK`. All other addresses select one of `NREG` control registers by their low address bits.

Top module: `lbus_slave_fsm`

## Requirements
- R1: After reset, `state` is 0, `hold_req` and `fifo_rd` are low, and every control register reads as zero.
- R2: In idle, `xfer_req` high moves `state` to 1 on the next clock, with `hold_req` high. While `hold_ack` is low, an address strobe is ignored and `state` stays 1.
- R3: In state 1, with `hold_ack` high and `ads_n` low, the address is captured. On the next clock `state` becomes 2 when `wr_nrd` is low (read) or 3 when `wr_nrd` is high (write).
- R4: In state 2, each clock with `ready` high, a FIFO-window address and a non-empty FIFO asserts `fifo_rd` for exactly that clock, and `rdata` equals `fifo_data`. No word is popped when `ready` is low.
- R5: A FIFO-window read beat with the FIFO empty returns zero on `rdata` and leaves `fifo_rd` low.
- R6: A read outside the FIFO window returns the control register selected by the address bits [log2(NREG)-1:0] and never pulses `fifo_rd`.
- R7: States 2 and 3 move to state 4 on the clock where `ready` is high and `last_n` is low. Otherwise they stay where they are.
- R8: A write stores `wdata` into the selected control register only on the beat with `ready` high and `last_n` low. Earlier beats and writes into the FIFO window leave the registers unchanged.
- R9: In state 4, `hold_req` is low, and the next clock returns `state` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_req | input | 1 | Bridge has an access pending |
| hold_req | output | 1 | Request for the local bus |
| hold_ack | input | 1 | Arbiter grant of the local bus |
| ads_n | input | 1 | Address strobe, active low, first clock of an access |
| last_n | input | 1 | Last-transfer strobe, active low |
| wr_nrd | input | 1 | 1 = write, 0 = read |
| ready | input | 1 | Data beat handshake |
| addr | input | ADDR_W | Local address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_data | input | DATA_W | Word at FIFO head |
| fifo_rd | output | 1 | FIFO pop strobe |
| ctrl | output | NREG*DATA_W | Control registers, register k in bits [k*DATA_W +: DATA_W] |
| state | output | 3 | Current state code |

## Verification
The properties assume that the arbiter grants only while the request is up. They also assume that `ready` and `last_n` are driven only while an access is in progress, and that the FIFO flag tracks its pops within one clock. The bench respects these assumptions. It raises `hold_ack` only after seeing state 1, and it pairs every access with one strobe. Its FIFO model updates emptiness on the same edge that it pops. Stalls, an ignored strobe before the grant, and empty-FIFO reads are placed inside otherwise legal accesses.

// File: rtl/lbus_slave_fsm.sv
module lbus_slave_fsm #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int NREG = 4,
  parameter logic [ADDR_W-1:0] FIFO_BASE = 8'h80,
  parameter logic [ADDR_W-1:0] FIFO_MASK = 8'h80
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   xfer_req,
  output logic                   hold_req,
  input  logic                   hold_ack,
  input  logic                   ads_n,
  input  logic                   last_n,
  input  logic                   wr_nrd,
  input  logic                   ready,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      wdata,
  output logic [DATA_W-1:0]      rdata,
  input  logic                   fifo_empty,
  input  logic [DATA_W-1:0]      fifo_data,
  output logic                   fifo_rd,
  output logic [NREG*DATA_W-1:0] ctrl,
  output logic [2:0]             state
);
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;
  localparam logic [2:0] S_IDLE = 3'd0, S_HOLD = 3'd1, S_RD = 3'd2,
                         S_WR = 3'd3, S_DONE = 3'd4;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] regs [NREG];
  logic              in_win, beat, last_beat, start;
  logic [IDX_W-1:0]  idx;

  assign in_win    = (addr_q & FIFO_MASK) == FIFO_BASE;
  assign idx       = addr_q[IDX_W-1:0];
  assign beat      = ready && (state == S_RD || state == S_WR);
  assign last_beat = beat && !last_n;
  assign start     = state == S_HOLD && hold_ack && !ads_n;
  assign hold_req  = state == S_HOLD || state == S_RD || state == S_WR;
  assign fifo_rd   = state == S_RD && ready && in_win && !fifo_empty;

  always_comb begin
    if (in_win) rdata = fifo_empty ? '0 : fifo_data;
    else        rdata = regs[idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      addr_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (xfer_req) state <= S_HOLD;
        S_HOLD: if (start) begin
          addr_q <= addr;
          state  <= wr_nrd ? S_WR : S_RD;
        end
        S_RD, S_WR: if (last_beat) state <= S_DONE;
        default: state <= S_IDLE;
      endcase
    end
  end

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs[k] <= '0;
      else if (state == S_WR && last_beat && !in_win && idx == IDX_W'(k))
        regs[k] <= wdata;
    end
    assign ctrl[k*DATA_W +: DATA_W] = regs[k];
  end
endmodule

// File: rtl/lbus_slave_fsm_chk.sv
module lbus_slave_fsm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] state,
  input logic       xfer_req,
  input logic       hold_req,
  input logic       hold_ack,
  input logic       ready,
  input logic       last_n,
  input logic       fifo_empty,
  input logic       fifo_rd
);
  a_r2_idle_to_hold: assert property (@(posedge clk) disable iff (!rst_n)
    state == 3'd0 && xfer_req |=> state == 3'd1 && hold_req);
  a_r2_wait_grant: assert property (@(posedge clk) disable iff (!rst_n)
    state == 3'd1 && !hold_ack |=> state == 3'd1);
  a_r5_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> !fifo_empty && ready);
  a_r4_pop_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> state == 3'd2);
  a_r7_exit_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd2 || state == 3'd3) && ready && !last_n |=> state == 3'd4);
  a_r7_stay_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd2 || state == 3'd3) && !(ready && !last_n) |=> $stable(state));
  a_r9_done_release: assert property (@(posedge clk) disable iff (!rst_n)
    state == 3'd4 |-> !hold_req);
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    state == 3'd4 |=> state == 3'd0);
  a_r1_legal_state: assert property (@(posedge clk) disable iff (!rst_n)
    state <= 3'd4);
endmodule

bind lbus_slave_fsm lbus_slave_fsm_chk u_chk (.*);

// File: tb/lbus_slave_fsm_bench.sv
module lbus_slave_fsm_bench;
  localparam int CLK_P = 10;
  localparam int DW = 32;

  logic clk = 0, rst_n = 0;
  logic xfer_req = 0, hold_ack = 0, ads_n = 1, last_n = 1, wr_nrd = 0, ready = 0;
  logic [7:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic hold_req, fifo_rd;
  logic [4*DW-1:0] ctrl;
  logic [2:0] state;
  logic [DW-1:0] fq[$];
  logic fifo_empty;
  logic [DW-1:0] fifo_data;
  logic [DW:0] exp_q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  assign fifo_empty = fq.size() == 0;
  assign fifo_data  = fifo_empty ? '0 : fq[0];

  lbus_slave_fsm u_lbus_slave_fsm (.*);

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) if (fifo_rd && fq.size() > 0) void'(fq.pop_front());

  task automatic check(bit ok, string req, logic [DW:0] act, logic [DW:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && state == 3'd2 && ready) begin
      logic [DW:0] e;
      if (exp_q.size() == 0) check(0, "R4 unexpected beat", {fifo_rd, rdata}, '0);
      else begin
        e = exp_q.pop_front();
        check({fifo_rd, rdata} === e, "R4/R5/R6 read beat", {fifo_rd, rdata}, e);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic access(bit wr, logic [7:0] a, int n, logic [DW-1:0] d);
    xfer_req = 1;
    tick();
    check(state == 3'd1 && hold_req, "R2 hold state", {state, hold_req}, {3'd1, 1'b1});
    xfer_req = 0; ads_n = 0; addr = a; wr_nrd = wr;
    tick();
    check(state == 3'd1, "R2 strobe ignored without grant", state, 1);
    hold_ack = 1;
    tick();
    ads_n = 1;
    check(state == (wr ? 3'd3 : 3'd2), "R3 access decode", state, wr ? 3 : 2);
    for (int i = 0; i < n; i++) begin
      if (i == 1) begin
        ready = 0; last_n = 1;
        tick();
        check(state == (wr ? 3'd3 : 3'd2), "R7 stall keeps state", state, wr ? 3 : 2);
      end
      ready = 1; last_n = (i == n - 1) ? 1'b0 : 1'b1;
      wdata = (i == n - 1) ? d : ~d;
      tick();
    end
    ready = 0; last_n = 1; hold_ack = 0;
    check(state == 3'd4 && !hold_req, "R9 completion", {state, hold_req}, {3'd4, 1'b0});
    tick();
    check(state == 3'd0, "R9 back to idle", state, 0);
  endtask

  initial begin
    #(CLK_P * 50000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 3) rst_n = 1;
    tick();
    check(state == 3'd0 && !hold_req && !fifo_rd && ctrl == '0, "R1 reset",
          {state, hold_req, fifo_rd}, '0);
    // R8: two beats, only the last one's data is stored
    access(1, 8'h01, 2, 32'hA5A5_0001);
    check(ctrl[DW +: DW] == 32'hA5A5_0001, "R8 register write", ctrl[DW +: DW], 32'hA5A5_0001);
    access(1, 8'h83, 1, 32'h0000_DEAD);
    check(ctrl[3*DW +: DW] == '0, "R8 window write ignored", ctrl[3*DW +: DW], 0);
    // R6: read a register outside the window
    exp_q.push_back({1'b0, 32'hA5A5_0001});
    access(0, 8'h01, 1, '0);
    exp_q.push_back({1'b0, 32'h0});
    access(0, 8'h03, 1, '0);
    // R4 then R5: three FIFO words, fourth beat hits an empty FIFO
    fq.push_back(32'h11); fq.push_back(32'h22); fq.push_back(32'h33);
    exp_q.push_back({1'b1, 32'h11}); exp_q.push_back({1'b1, 32'h22});
    exp_q.push_back({1'b1, 32'h33}); exp_q.push_back({1'b0, 32'h0});
    access(0, 8'h80, 4, '0);
    check(fq.size() == 0, "R4 pop count", fq.size(), 0);
    exp_q.push_back({1'b0, 32'h0}); exp_q.push_back({1'b0, 32'h0});
    access(0, 8'hC4, 2, '0);
    check(exp_q.size() == 0, "R4 all beats seen", exp_q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule